// File: doc/BRIEF.md
# Bus-Mapped General-Purpose I/O Controller

This block is a memory-mapped general-purpose I/O peripheral with a parameterised pin count. A bus master reaches seven word registers through a single-cycle strobe and acknowledge slave port. The registers cover the sampled pin inputs, the output data, the output enables, a per-pin interrupt mask, a per-pin trigger polarity, a per-pin auxiliary select and a control word.

The pin inputs can be captured on every bus clock. They can also be captured only on the rising edge, or only on the falling edge, of an external sampling clock. That clock is synchronised into the bus domain before its edges are detected.

Each output pin is driven either by the output register or by the matching bit of an auxiliary input bus, bit by bit. The output-enable bus toward the pads is active low. A single interrupt request combines level triggers from the enabled pins under a global enable, and a sticky pending bit holds the request until software clears it.

Top module: `bus_gpio`

## Requirements
- R1: After synchronous reset, every register reads zero, `pins_out` is all zeros, `pins_oe_n` is all ones and `irq` is low.
- R2: Each strobe (`cyc_i` and `stb_i` high) is answered by `ack_o` high for exactly one cycle, in the cycle after the strobe is presented. `dat_o` is valid while `ack_o` is high.
- R3: The word addresses are 0 for the sampled input register (read-only), 1 for output data, 2 for output enable, 3 for interrupt mask, 4 for trigger polarity, 5 for auxiliary select and 6 for control. Address 7 reads zero. While control bit 0 (external-clock select) is clear, a pin change can be read back from address 0 no later than the second bus clock after it.
- R4: With control bit 0 set and control bit 1 (falling-edge select) clear, the input register updates only on a rising edge of `ext_clk`. Pin changes without such an edge, and falling edges, leave it unchanged.
- R5: With control bits 0 and 1 both set, the input register updates only on a falling edge of `ext_clk`. A rising edge leaves it unchanged.
- R6: `pins_out` equals `(aux_in & AUX) | (OUT & ~AUX)` bit by bit. With AUX all zero it mirrors the output register.
- R7: `pins_oe_n` is the bitwise inverse of the output-enable register.
- R8: A write updates only the byte lanes whose `sel_i` bit is set. A write to address 0 has no effect on the value read back from it.
- R9: Register bits at and above the pin count N are not stored and read as zero.
- R10: A pin triggers when its polarity bit is 0 and its sampled input is low, or when its polarity bit is 1 and its sampled input is high. `irq` rises only when control bit 2 (global enable) is set, the pin's mask bit is set and that pin triggers. Otherwise it stays low.
- R11: Control bit 3 (pending) is set by hardware when an enabled trigger occurs. It stays set after the trigger condition goes away, until software writes it to zero. `irq` is pending AND global enable. Writing zero to the control register drops `irq` within two bus clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Transfer strobe |
| we_i | input | 1 | Write (1) or read (0) |
| adr_i | input | 3 | Word address of the register |
| dat_i | input | 32 | Write data |
| sel_i | input | 4 | Byte-lane enables for writes |
| dat_o | output | 32 | Read data |
| ack_o | output | 1 | Transfer acknowledge |
| pins_in | input | N | Pin input levels |
| aux_in | input | N | Auxiliary output sources |
| ext_clk | input | 1 | External sampling clock |
| pins_out | output | N | Pin output levels |
| pins_oe_n | output | N | Active-low pin output enables |
| irq | output | 1 | Interrupt request |

## Verification
The bench moves the input pins while the external clock is idle, then gives only the opposite edge of the one selected, and checks that the read-back value stays frozen. A sampler that ignored the mode or the edge choice would return the new pin value early. It drives partial byte-lane writes, wide writes past the pin count, and a write to the read-only input address. A design that merged lanes wrongly, or kept bits above the pin count, would read back a wrong word. For the interrupt, it first holds the trigger condition while the global enable is off, and then while only a different pin is masked in, and expects no request. It then removes the condition and expects the request to stay latched until a control write of zero. A non-sticky or polarity-swapped design would drop the request too early or raise it in the wrong cases.

// File: rtl/bus_gpio_pkg.sv
package bus_gpio_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [2:0] {
    A_IN    = 3'd0,
    A_OUT   = 3'd1,
    A_OE    = 3'd2,
    A_INTE  = 3'd3,
    A_PTRIG = 3'd4,
    A_AUX   = 3'd5,
    A_CTRL  = 3'd6
  } reg_addr_e;

  // control word, bit 0 at the right
  typedef struct packed {
    logic pend;   // bit 3
    logic ien;    // bit 2
    logic fall;   // bit 1
    logic eclk;   // bit 0
  } ctrl_t;
endpackage

// File: rtl/bus_gpio_sampler.sv
module bus_gpio_sampler #(
  parameter int N    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_clk,
  input  logic         eclk_mode,
  input  logic         fall_sel,
  input  logic [N-1:0] pins_in,
  output logic [N-1:0] in_q,
  output logic         cap_en
);
  // sh[SYNC-1] is the synchronised level, sh[SYNC] its previous value
  logic [SYNC:0] sh;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC-1:0], ext_clk};
  end

  assign rise   = sh[SYNC-1] & ~sh[SYNC];
  assign fall   = ~sh[SYNC-1] & sh[SYNC];
  assign cap_en = eclk_mode ? (fall_sel ? fall : rise) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst)         in_q <= '0;
    else if (cap_en) in_q <= pins_in;
  end
endmodule

// File: rtl/bus_gpio_trig.sv
module bus_gpio_trig #(
  parameter int N = 16
) (
  input  logic [N-1:0] in_q,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] pol,
  output logic         any_hit
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = mask[i] & ~(in_q[i] ^ pol[i]);
  end

  assign any_hit = |hit;
endmodule

// File: rtl/bus_gpio_pins.sv
module bus_gpio_pins #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] out_q,
  input  logic [N-1:0] aux_q,
  input  logic [N-1:0] oe_q,
  input  logic [N-1:0] aux_in,
  output logic [N-1:0] pins_out,
  output logic [N-1:0] pins_oe_n
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pins_out[i]  <= 1'b0;
        pins_oe_n[i] <= 1'b1;
      end else begin
        pins_out[i]  <= aux_q[i] ? aux_in[i] : out_q[i];
        pins_oe_n[i] <= ~oe_q[i];
      end
    end
  end
endmodule

// File: rtl/bus_gpio_regs.sv
module bus_gpio_regs
  import bus_gpio_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [2:0]        adr_i,
  input  logic [WORD_W-1:0] dat_i,
  input  logic [LANES-1:0]  sel_i,
  output logic [WORD_W-1:0] dat_o,
  output logic              ack_o,
  input  logic [N-1:0]      in_q,
  input  logic              any_hit,
  output logic [N-1:0]      out_q,
  output logic [N-1:0]      oe_q,
  output logic [N-1:0]      inte_q,
  output logic [N-1:0]      ptrig_q,
  output logic [N-1:0]      aux_q,
  output logic              eclk_o,
  output logic              fall_o,
  output logic              irq
);
  function automatic logic [N-1:0] lane_merge(input logic [N-1:0] old,
                                               input logic [WORD_W-1:0] wd,
                                               input logic [LANES-1:0] be);
    logic [WORD_W-1:0] base, res;
    base = '0;
    base[N-1:0] = old;
    for (int b = 0; b < LANES; b++)
      res[b*8 +: 8] = be[b] ? wd[b*8 +: 8] : base[b*8 +: 8];
    return res[N-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] zext(input logic [N-1:0] v);
    logic [WORD_W-1:0] r;
    r = '0;
    r[N-1:0] = v;
    return r;
  endfunction

  ctrl_t             ctrl_q, ctrl_nx;
  logic              go, wr;
  logic [WORD_W-1:0] rd_word;

  assign go = cyc_i & stb_i & ~ack_o;
  assign wr = go & we_i;

  always_comb begin
    ctrl_nx = ctrl_q;
    if (wr && adr_i == A_CTRL && sel_i[0]) ctrl_nx = ctrl_t'(dat_i[3:0]);
    if (ctrl_nx.ien && any_hit) ctrl_nx.pend = 1'b1;
  end

  always_comb begin
    case (reg_addr_e'(adr_i))
      A_IN:    rd_word = zext(in_q);
      A_OUT:   rd_word = zext(out_q);
      A_OE:    rd_word = zext(oe_q);
      A_INTE:  rd_word = zext(inte_q);
      A_PTRIG: rd_word = zext(ptrig_q);
      A_AUX:   rd_word = zext(aux_q);
      A_CTRL:  rd_word = {{(WORD_W-4){1'b0}}, ctrl_q};
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o   <= 1'b0;
      dat_o   <= '0;
      out_q   <= '0;
      oe_q    <= '0;
      inte_q  <= '0;
      ptrig_q <= '0;
      aux_q   <= '0;
      ctrl_q  <= '0;
      irq     <= 1'b0;
    end else begin
      ack_o  <= go;
      if (go) dat_o <= rd_word;
      if (wr) begin
        case (reg_addr_e'(adr_i))
          A_OUT:   out_q   <= lane_merge(out_q,   dat_i, sel_i);
          A_OE:    oe_q    <= lane_merge(oe_q,    dat_i, sel_i);
          A_INTE:  inte_q  <= lane_merge(inte_q,  dat_i, sel_i);
          A_PTRIG: ptrig_q <= lane_merge(ptrig_q, dat_i, sel_i);
          A_AUX:   aux_q   <= lane_merge(aux_q,   dat_i, sel_i);
          default: ;
        endcase
      end
      ctrl_q <= ctrl_nx;
      irq    <= ctrl_nx.ien & ctrl_nx.pend;
    end
  end

  assign eclk_o = ctrl_q.eclk;
  assign fall_o = ctrl_q.fall;
endmodule

// File: rtl/bus_gpio.sv
module bus_gpio
  import bus_gpio_pkg::*;
#(
  parameter int N    = 16,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [2:0]        adr_i,
  input  logic [WORD_W-1:0] dat_i,
  input  logic [LANES-1:0]  sel_i,
  output logic [WORD_W-1:0] dat_o,
  output logic              ack_o,
  input  logic [N-1:0]      pins_in,
  input  logic [N-1:0]      aux_in,
  input  logic              ext_clk,
  output logic [N-1:0]      pins_out,
  output logic [N-1:0]      pins_oe_n,
  output logic              irq
);
  logic [N-1:0] in_q, out_q, oe_q, inte_q, ptrig_q, aux_q;
  logic         cap_en, any_hit, eclk_mode, fall_sel;

  bus_gpio_sampler #(.N(N), .SYNC(SYNC)) u_smp (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .eclk_mode(eclk_mode),
    .fall_sel(fall_sel), .pins_in(pins_in), .in_q(in_q), .cap_en(cap_en)
  );

  bus_gpio_trig #(.N(N)) u_trig (
    .in_q(in_q), .mask(inte_q), .pol(ptrig_q), .any_hit(any_hit)
  );

  bus_gpio_regs #(.N(N)) u_regs (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .dat_i(dat_i), .sel_i(sel_i), .dat_o(dat_o), .ack_o(ack_o),
    .in_q(in_q), .any_hit(any_hit), .out_q(out_q), .oe_q(oe_q),
    .inte_q(inte_q), .ptrig_q(ptrig_q), .aux_q(aux_q),
    .eclk_o(eclk_mode), .fall_o(fall_sel), .irq(irq)
  );

  bus_gpio_pins #(.N(N)) u_pins (
    .clk(clk), .rst(rst), .out_q(out_q), .aux_q(aux_q), .oe_q(oe_q),
    .aux_in(aux_in), .pins_out(pins_out), .pins_oe_n(pins_oe_n)
  );
endmodule

// File: rtl/bus_gpio_chk.sv
module bus_gpio_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cyc_i,
  input logic         stb_i,
  input logic         we_i,
  input logic [2:0]   adr_i,
  input logic         ack_o,
  input logic         irq,
  input logic [N-1:0] pins_oe_n,
  input logic [N-1:0] in_q,
  input logic         cap_en,
  input logic         any_hit
);
  logic wr_ctrl;
  assign wr_ctrl = cyc_i & stb_i & we_i & ~ack_o & (adr_i == 3'd6);

  // R2
  ack_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  // R2
  ack_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(cyc_i && stb_i));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && pins_oe_n == {N{1'b1}}));

  // R4
  in_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(in_q) |-> $past(cap_en));

  // R10
  irq_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(any_hit));

  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !wr_ctrl) |=> irq);
endmodule

bind bus_gpio bus_gpio_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
  .adr_i(adr_i), .ack_o(ack_o), .irq(irq), .pins_oe_n(pins_oe_n),
  .in_q(in_q), .cap_en(cap_en), .any_hit(any_hit)
);

// File: tb/bus_gpio_tb.sv
`timescale 1ns/1ps
module bus_gpio_tb;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cyc_i = 1'b0, stb_i = 1'b0, we_i = 1'b0;
  logic [2:0]    adr_i = '0;
  logic [31:0]   dat_i = '0;
  logic [3:0]    sel_i = '0;
  logic [31:0]   dat_o;
  logic          ack_o;
  logic [N-1:0]  pins_in = '0, aux_in = '0;
  logic          ext_clk = 1'b0;
  logic [N-1:0]  pins_out, pins_oe_n;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q[$];
  bit          rd_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  bus_gpio #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .dat_i(dat_i), .sel_i(sel_i), .dat_o(dat_o), .ack_o(ack_o),
    .pins_in(pins_in), .aux_in(aux_in), .ext_clk(ext_clk),
    .pins_out(pins_out), .pins_oe_n(pins_oe_n), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected item per acknowledge
  always @(negedge clk) begin
    if (!rst && ack_o) begin
      if (rd_q.size() == 0) begin
        chk("R2 ack without request", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        bit r;
        string t;
        e = exp_q.pop_front();
        r = rd_q.pop_front();
        t = tag_q.pop_front();
        if (r) chk(t, dat_o, e);
      end
    end
  end

  task automatic xfer(input bit we, input logic [2:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cyc_i = 1'b1; stb_i = 1'b1; we_i = we; adr_i = a; dat_i = d; sel_i = be;
    exp_q.push_back(exp); rd_q.push_back(!we); tag_q.push_back(tag);
    @(negedge clk);
    chk("R2 ack one cycle after strobe", {31'd0, ack_o}, 32'd1);
    cyc_i = 1'b0; stb_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    xfer(1'b1, a, d, 4'hF, 32'd0, "write");
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    xfer(1'b0, a, 32'd0, 4'h0, exp, tag);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    // R1
    chk("R1 pins_out", {16'd0, pins_out}, 32'd0);
    chk("R1 pins_oe_n", {16'd0, pins_oe_n}, 32'h0000_FFFF);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 7; a++) rd(3'(a), 32'd0, "R1 register reset value");
    wait_clk(1);
    chk("R2 ack dropped", {31'd0, ack_o}, 32'd0);

    // R3 bus-clock sampling
    pins_in = 16'hA5C3;
    rd(3'd0, 32'h0000_A5C3, "R3 input read");
    pins_in = 16'h5A01;
    rd(3'd0, 32'h0000_5A01, "R3 input read second pattern");
    rd(3'd7, 32'd0, "R3 unused address");

    // R6 / R7
    wr(3'd1, 32'h0000_3C3C);
    wait_clk(2);
    chk("R6 pins mirror OUT", {16'd0, pins_out}, 32'h0000_3C3C);
    wr(3'd2, 32'h0000_0F0F);
    wait_clk(2);
    chk("R7 oe_n inverse", {16'd0, pins_oe_n}, 32'h0000_F0F0);
    aux_in = 16'hAAAA;
    wr(3'd5, 32'h0000_F0F0);
    wait_clk(2);
    chk("R6 aux mux", {16'd0, pins_out}, 32'h0000_ACAC);
    aux_in = 16'h5555;
    wait_clk(2);
    chk("R6 aux follows aux_in", {16'd0, pins_out}, 32'h0000_5C5C);

    // R8 byte lanes, R9 upper bits
    wr(3'd1, 32'h0000_1234);
    xfer(1'b1, 3'd1, 32'h0000_ABCD, 4'b0010, 32'd0, "write");
    rd(3'd1, 32'h0000_AB34, "R8 byte lane merge");
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, 32'h0000_FFFF, "R9 upper bits read zero");
    wr(3'd3, 32'd0);
    wr(3'd5, 32'd0);

    // R4 rising edge of external clock
    pins_in = 16'h1111;
    rd(3'd0, 32'h0000_1111, "R3 input before ext mode");
    wr(3'd6, 32'h1);
    pins_in = 16'h2222;
    wait_clk(6);
    rd(3'd0, 32'h0000_1111, "R4 no edge keeps input");
    ext_clk = 1'b1;
    wait_clk(5);
    rd(3'd0, 32'h0000_2222, "R4 rising edge captures");
    pins_in = 16'h3333;
    ext_clk = 1'b0;
    wait_clk(5);
    rd(3'd0, 32'h0000_2222, "R4 falling edge ignored");
    wr(3'd0, 32'h0000_FFFF);
    rd(3'd0, 32'h0000_2222, "R8 write to input ignored");

    // R5 falling edge of external clock
    wr(3'd6, 32'h3);
    pins_in = 16'h4444;
    ext_clk = 1'b1;
    wait_clk(5);
    rd(3'd0, 32'h0000_2222, "R5 rising edge ignored");
    ext_clk = 1'b0;
    wait_clk(5);
    rd(3'd0, 32'h0000_4444, "R5 falling edge captures");

    // R10 interrupt gating and polarity
    wr(3'd6, 32'h0);
    pins_in = 16'hFFFE;
    wr(3'd4, 32'h0);
    wr(3'd3, 32'h0000_0001);
    wait_clk(3);
    chk("R10 no irq without global enable", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'h0000_0002);
    wr(3'd6, 32'h4);
    wait_clk(3);
    chk("R10 no irq for unmasked pin", {31'd0, irq}, 32'd0);
    pins_in = 16'hFFFC;
    wait_clk(3);
    chk("R10 irq on low level", {31'd0, irq}, 32'd1);

    // R11 sticky pending and clear
    pins_in = 16'hFFFF;
    wait_clk(4);
    chk("R11 irq stays set", {31'd0, irq}, 32'd1);
    rd(3'd6, 32'h0000_000C, "R11 pending bit set");
    wr(3'd6, 32'h0);
    wait_clk(1);
    chk("R11 irq cleared", {31'd0, irq}, 32'd0);
    rd(3'd6, 32'h0000_0000, "R11 control cleared");

    // R10 high polarity
    wr(3'd4, 32'h0000_0002);
    pins_in = 16'h0000;
    wr(3'd6, 32'h4);
    wait_clk(3);
    chk("R10 no irq high polarity pin low", {31'd0, irq}, 32'd0);
    pins_in = 16'h0002;
    wait_clk(3);
    chk("R10 irq on high level", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'h0);
    wait_clk(2);
    chk("R11 irq cleared again", {31'd0, irq}, 32'd0);

    wait_clk(2);
    chk("R2 scoreboard drained", rd_q.size(), 32'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule